// File: doc/BRIEF.md
# Pipelined Four-Tap Sliding Sum

This block takes a stream of unsigned 8-bit samples and, for each sample it accepts, forms the sum of that sample and the three samples before it. Sums wrap modulo 256. A sample is accepted on a rising clock edge where the input strobe is high. Cycles with the strobe low are idle and change nothing.

The four-operand sum is split into two register stages of two-input adders. The first stage holds two partial sums: the newest pair and the older pair. The second stage adds the partial sums into the output register. Both stages advance only on accepting edges. So the result for sample n appears on the edge that accepts sample n+1, and it is held through any idle cycles.

A saturating fill counter decides whether a result is valid. It needs three earlier samples. The valid flag travels through both stages beside its data. While the result is not valid, the data output carries zero.

Top module: `sum4_pipe`

## Requirements
- R1: While `rst_n` is low, and after its release until the first accepted sample, `out_valid` is 0 and `out_data` is 0.
- R2: For the n-th accepted sample with n >= 4, the reported value is (x(n) + x(n-1) + x(n-2) + x(n-3)) mod 256, where x(k) is the k-th accepted sample.
- R3: The results for the first three accepted samples after reset have `out_valid` = 0, and `out_data` is 0 whenever `out_valid` is 0.
- R4: The result for sample n appears on `out_valid`/`out_data` at the rising edge that accepts sample n+1. It is visible from that edge on, and not before.
- R5: A rising edge with `in_valid` low leaves `out_valid`, `out_data` and the sample history unchanged.
- R6: All partial and final sums wrap modulo 256. For example, four samples of 255 give 252.
- R7: Once a result is valid, every later result is valid for any length of stream. The fill count saturates.
- R8: Asserting `rst_n` in the middle of a stream clears the history and the fill count. The first three samples after release are again invalid, and the sum for the fourth sample after release uses no sample accepted before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Sample strobe; high accepts `in_data` at this edge |
| in_data | input | 8 | Unsigned input sample |
| out_valid | output | 1 | High when `out_data` is a valid four-sample sum |
| out_data | output | 8 | Sum for the previous accepted sample, or 0 when invalid |

## Verification
Two things happen on the same accepting edge: the history shifts in the new sample, and the second stage publishes the sum for the sample before it. A slip by one edge in either would pair the wrong taps with the reported value. Long back-to-back runs provoke this, and so do runs broken by idle gaps of several lengths. After every edge the bench compares both outputs against a sum it computes from its own record of accepted samples. Fill completion is also judged right at the edge where the fourth sample's result appears, including after a reset in mid-stream. Value sweeps reach the wrap boundaries.

// File: rtl/sum4_pkg.sv
package sum4_pkg;
  // number of taps in the window and earlier samples needed for a valid result
  localparam int unsigned TAPS = 4;
  localparam int unsigned FILL = TAPS - 1;
  // fill counter saturates one past the threshold
  localparam int unsigned CNT_MAX = TAPS;
  localparam int unsigned CNT_W = $clog2(CNT_MAX + 1);

  typedef logic [CNT_W-1:0] fill_cnt_t;
endpackage

// File: rtl/sum4_history.sv
module sum4_history
  import sum4_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] tap1,
  output logic [DATA_W-1:0] tap2,
  output logic [DATA_W-1:0] tap3,
  output logic              full
);
  logic [DATA_W-1:0] hist_q [1:FILL];
  logic [DATA_W-1:0] hist_d [1:FILL];
  fill_cnt_t cnt_q, cnt_d;

  // shift chain: slot 1 takes the new sample, slot k takes slot k-1
  always_comb hist_d[1] = acc ? din : hist_q[1];

  for (genvar k = 2; k <= FILL; k++) begin : g_shift
    always_comb hist_d[k] = acc ? hist_q[k-1] : hist_q[k];
  end

  for (genvar k = 1; k <= FILL; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q[k] <= '0;
      else        hist_q[k] <= hist_d[k];
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (acc && (cnt_q != fill_cnt_t'(CNT_MAX)))
      cnt_d = cnt_q + fill_cnt_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tap1 = hist_q[1];
  assign tap2 = hist_q[2];
  assign tap3 = hist_q[3];
  assign full = (cnt_q >= fill_cnt_t'(FILL));

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= fill_cnt_t'(CNT_MAX)); // R7
  AST_HIST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(tap1) && $stable(tap2) && $stable(tap3)); // R5
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> full); // R7
endmodule

// File: rtl/sum4_stage1.sv
module sum4_stage1 #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] tap1,
  input  logic [DATA_W-1:0] tap2,
  input  logic [DATA_W-1:0] tap3,
  input  logic              full,
  output logic [DATA_W-1:0] pair_new,
  output logic [DATA_W-1:0] pair_old,
  output logic              vld
);
  logic [DATA_W-1:0] new_d, old_d;
  logic              vld_d;

  always_comb begin
    new_d = pair_new;
    old_d = pair_old;
    vld_d = vld;
    if (acc) begin
      new_d = din + tap1;
      old_d = tap2 + tap3;
      vld_d = full;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_new <= '0;
      pair_old <= '0;
      vld      <= 1'b0;
    end else begin
      pair_new <= new_d;
      pair_old <= old_d;
      vld      <= vld_d;
    end
  end
endmodule

// File: rtl/sum4_stage2.sv
module sum4_stage2 #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [DATA_W-1:0] pair_new,
  input  logic [DATA_W-1:0] pair_old,
  input  logic              vld_in,
  output logic [DATA_W-1:0] sum_q,
  output logic              vld_q
);
  logic [DATA_W-1:0] sum_d;
  logic [DATA_W-1:0] total;
  logic              vld_d;

  assign total = pair_new + pair_old;

  always_comb begin
    sum_d = sum_q;
    vld_d = vld_q;
    if (acc) begin
      sum_d = vld_in ? total : '0;
      vld_d = vld_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sum_q <= sum_d;
      vld_q <= vld_d;
    end
  end
endmodule

// File: rtl/sum4_pipe.sv
module sum4_pipe
  import sum4_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic [DATA_W-1:0] tap1, tap2, tap3;
  logic              full;
  logic [DATA_W-1:0] pair_new, pair_old;
  logic              s1_vld;

  sum4_history #(.DATA_W(DATA_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .acc(in_valid), .din(in_data),
    .tap1(tap1), .tap2(tap2), .tap3(tap3), .full(full)
  );

  sum4_stage1 #(.DATA_W(DATA_W)) u_s1 (
    .clk(clk), .rst_n(rst_n), .acc(in_valid), .din(in_data),
    .tap1(tap1), .tap2(tap2), .tap3(tap3), .full(full),
    .pair_new(pair_new), .pair_old(pair_old), .vld(s1_vld)
  );

  sum4_stage2 #(.DATA_W(DATA_W)) u_s2 (
    .clk(clk), .rst_n(rst_n), .acc(in_valid),
    .pair_new(pair_new), .pair_old(pair_old), .vld_in(s1_vld),
    .sum_q(out_data), .vld_q(out_valid)
  );

  AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_data == '0); // R3
  AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data) && $stable(out_valid)); // R5
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid); // R7
  AST_RISE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid)); // R4
endmodule

// File: tb/sim_sum4_pipe.sv
module sim_sum4_pipe;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_data;
  logic       out_valid;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  int m = 0;
  logic [7:0] samp [0:4095];
  int cycles = 0;

  always #2.5 clk = ~clk; // 200 MHz

  sum4_pipe #(.DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input string req, input logic ev, input logic [7:0] ed);
    checks++;
    if (out_valid !== ev || out_data !== ed) begin
      errors++;
      $display("FAIL %s: got valid=%0b data=%0d, expected valid=%0b data=%0d",
               req, out_valid, out_data, ev, ed);
    end
  endtask

  // expected output after m samples accepted since reset
  task automatic check_model(input string req);
    int n;
    logic ev;
    logic [7:0] ed;
    n  = m - 1;
    ev = (n >= 4);
    ed = 8'd0;
    if (ev) ed = samp[n] + samp[n-1] + samp[n-2] + samp[n-3];
    check(req, ev, ed);
  endtask

  // called at a negedge; accepts x on the next rising edge
  task automatic send(input logic [7:0] x, input string req);
    in_valid = 1'b1;
    in_data  = x;
    @(negedge clk);
    m++;
    samp[m] = x;
    check_model(req);
  endtask

  task automatic idle(input int k, input string req);
    in_valid = 1'b0;
    in_data  = 8'hA5;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      check_model(req);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    #1;
    check("R1 reset asserted", 1'b0, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    m = 0;
    @(negedge clk);
    check("R1 after release", 1'b0, 8'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: got cycles=%0d, expected under 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = 8'd0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 1'b0, 8'd0);

    // worked stream, R2/R3/R4: valid 95, 62, 88 appear one sample later
    send(8'd45, "R3 fill 1");
    send(8'd8,  "R3 fill 2");
    send(8'd23, "R3 fill 3");
    send(8'd19, "R4 fill 4 not yet visible");
    send(8'd12, "R2 sample 4 = 95");
    idle(3, "R5 hold 95");
    send(8'd34, "R2 sample 5 = 62");
    send(8'd0,  "R2 sample 6 = 88");
    idle(2, "R5 hold");

    // wrap, R6
    do_reset();
    for (int i = 0; i < 5; i++) send(8'd255, "R6 wrap 255s");
    send(8'd1, "R6 wrap");
    send(8'd128, "R6 wrap");
    send(8'd128, "R6 wrap");

    // sweep of values back to back and with gaps, R2/R7
    do_reset();
    for (int v = 0; v < 1024; v++) begin
      send(8'((v * 37 + 11) ^ (v >> 3)), "R2 sweep");
      if (v % 7 == 3) idle(v % 4 + 1, "R5 gap");
    end
    check_model("R7 valid after long run");

    // exhaustive byte values across all tap positions
    for (int v = 0; v < 256; v++) send(8'(v), "R2 ramp");
    for (int v = 0; v < 256; v++) send(8'(255 - v), "R6 down ramp");

    // mid-stream reset, R8
    send(8'd200, "R8 pre");
    send(8'd201, "R8 pre");
    do_reset();
    send(8'd1, "R8 fill 1");
    send(8'd2, "R8 fill 2");
    send(8'd3, "R8 fill 3");
    send(8'd4, "R8 fill 4");
    send(8'd5, "R8 first valid 10");
    check("R8 explicit sum", 1'b1, 8'd10);
    idle(2, "R5 end");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule